// File: doc/BRIEF.md
# Parity-Protected Four-Way Cache Array with Defective-Way Exclusion

This block is a small four-way set-associative tag and data array with its own replacement control. Every stored line carries one parity bit taken over its tag and data together. The bit is produced when a line is filled and checked again each time a lookup reads the set. When a check fails, that way of that set is taken out of service through a per-set enable mask. The replacement choice never picks a way whose enable bit is clear, and a lookup never hits in one.

A lookup is issued with a set index and a tag and is answered one cycle later with hit, data, a parity-error flag and an uncacheable flag. A set whose four ways are all disabled answers every lookup as an uncacheable miss and drops every fill aimed at it. A fill writes a tag and data into the victim way of its set. A fault-injection input on the fill path stores the inverted parity bit, so that detection can be exercised. A programmable cycle counter restores every enable mask to all ones when it reaches its terminal count. A short-lived upset therefore does not keep a way out of use for good.

Top module: `cache_parity_lru`

## Requirements
- R1: A lookup with `req_valid` high is answered on the following cycle with `rsp_valid` high for exactly one cycle. A cycle without a request gives `rsp_valid` low on the next cycle.
- R2: A lookup whose tag matches a valid, enabled way with correct parity returns `rsp_hit`=1 and that line's data. Any other lookup returns `rsp_hit`=0.
- R3: A fill stores even parity over {tag, data}. With `fill_bad_par`=1 the stored parity bit is inverted, so the line fails its next check.
- R4: A lookup that finds a parity mismatch in any valid, enabled way of the set returns `rsp_perr`=1 and gets no hit from that way. It also clears that way's enable bit.
- R5: A disabled way is neither checked nor matched. A repeated lookup of a line whose way was disabled returns `rsp_perr`=0 and `rsp_hit`=0.
- R6: The fill victim is the lowest-numbered enabled way that holds no valid line. If every enabled way is valid, the victim is the least recently used enabled way. A disabled way is never chosen.
- R7: A lookup hit and a fill each make the way concerned the most recently used way of its set.
- R8: When all four enable bits of a set are clear, lookups return `rsp_uncache`=1 with `rsp_hit`=0, and fills to that set store nothing.
- R9: With `scrub_period`=P nonzero, a counter advances every cycle. When it reaches P, all enable masks return to all ones and the counter restarts, so this happens every P+1 cycles. With P=0 the counter is held at zero and masks are never restored.
- R10: When a parity error and a mask restore fall in the same cycle, the detected way ends up disabled.
- R11: A lookup and a fill to the same set in the same cycle both take effect. The lookup sees the contents from before the fill, the victim is chosen from the ages from before the lookup, and the filled way becomes most recently used.
- R12: After reset, all lines are invalid, all masks are all ones, the scrub counter is zero and the response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scrub_period | input | CNT_W | Cycles between mask restores; 0 disables restores |
| req_valid | input | 1 | Lookup request |
| req_index | input | log2(NSETS) | Lookup set index |
| req_tag | input | TAG_W | Lookup tag |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | DATA_W | Data of the hit line, zero on miss |
| rsp_perr | output | 1 | Parity mismatch found in the looked-up set |
| rsp_uncache | output | 1 | All ways of the set disabled |
| fill_valid | input | 1 | Fill request |
| fill_index | input | log2(NSETS) | Fill set index |
| fill_tag | input | TAG_W | Fill tag |
| fill_data | input | DATA_W | Fill data |
| fill_bad_par | input | 1 | Store inverted parity (fault injection) |

## Verification
The clearing of an enable bit by a failed parity check can land on the same clock edge as the periodic restore of every mask. The bench provokes this by storing a line with bad parity. It then sets the restore period from a held counter and counts edges, so that the lookup of that line meets the terminal count. The outcome is judged at the ports. The bench fills four more tags into the set and looks up the oldest of them. That tag must miss, because only three ways remain usable; had the restore won, it would hit. A second overlap, a lookup and a fill to the same set in one cycle, is checked through the old line's hit answer and its absence afterwards.

// File: rtl/cache_par_pkg.sv
package cache_par_pkg;

    localparam int NWAYS = 4;
    localparam int WAY_W = 2;
    localparam int AGE_W = 2;

    typedef logic [NWAYS-1:0] wayvec_t;
    typedef logic [AGE_W-1:0] age_t;
    typedef age_t [NWAYS-1:0] agevec_t;
    typedef logic [WAY_W-1:0] wayidx_t;

    typedef struct packed {
        logic    ok;
        wayidx_t way;
    } pick_t;

    typedef struct packed {
        logic    hit;
        logic    perr;
        logic    uncache;
        wayidx_t way;
    } look_t;

    // Lowest set bit of a way vector.
    function automatic wayidx_t lowest_way(wayvec_t v);
        wayidx_t r;
        r = '0;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (v[i]) r = wayidx_t'(i);
        end
        return r;
    endfunction

    // Invalid enabled way first, otherwise oldest enabled way.
    function automatic pick_t choose_victim(wayvec_t en, wayvec_t vld, agevec_t age);
        pick_t r;
        age_t  best;
        logic  got_inv;
        r       = '0;
        best    = '0;
        got_inv = 1'b0;
        for (int i = 0; i < NWAYS; i++) begin
            if (en[i] && !vld[i] && !got_inv) begin
                r.ok    = 1'b1;
                r.way   = wayidx_t'(i);
                got_inv = 1'b1;
            end
        end
        if (!got_inv) begin
            for (int i = 0; i < NWAYS; i++) begin
                if (en[i] && (!r.ok || age[i] > best)) begin
                    r.ok  = 1'b1;
                    r.way = wayidx_t'(i);
                    best  = age[i];
                end
            end
        end
        return r;
    endfunction

    // Make way w youngest; ways younger than w age by one.
    function automatic agevec_t touch_age(agevec_t a, wayidx_t w);
        agevec_t r;
        for (int i = 0; i < NWAYS; i++) begin
            if (wayidx_t'(i) == w)  r[i] = '0;
            else if (a[i] < a[w])   r[i] = a[i] + age_t'(1);
            else                    r[i] = a[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cache_par_store.sv
module cache_par_store
    import cache_par_pkg::*;
#(
    parameter int NSETS  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NSETS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [IDX_W-1:0]              rd_index,
    output logic [NWAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [NWAYS-1:0][DATA_W-1:0]  rd_data,
    output wayvec_t                       rd_vld,
    output wayvec_t                       rd_bad,
    input  logic [IDX_W-1:0]              fl_index,
    output wayvec_t                       fl_vld,
    input  logic                          wr_en,
    input  wayidx_t                       wr_way,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          wr_flip
);

    logic wr_par;
    assign wr_par = (^{wr_tag, wr_data}) ^ wr_flip;

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        logic [TAG_W-1:0]  tag_m  [NSETS];
        logic [DATA_W-1:0] data_m [NSETS];
        logic              par_m  [NSETS];
        logic              vld_m  [NSETS];
        logic              sel;

        assign sel = wr_en && (wr_way == wayidx_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < NSETS; s++) vld_m[s] <= 1'b0;
            end else if (sel) begin
                vld_m[wr_index_cast(fl_index)] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_m[fl_index]  <= wr_tag;
                data_m[fl_index] <= wr_data;
                par_m[fl_index]  <= wr_par;
            end
        end

        assign rd_tag[g]  = tag_m[rd_index];
        assign rd_data[g] = data_m[rd_index];
        assign rd_vld[g]  = vld_m[rd_index];
        assign rd_bad[g]  = vld_m[rd_index] &&
                            ((^{tag_m[rd_index], data_m[rd_index]}) != par_m[rd_index]);
        assign fl_vld[g]  = vld_m[fl_index];
    end

    function automatic logic [IDX_W-1:0] wr_index_cast(logic [IDX_W-1:0] i);
        return i;
    endfunction

endmodule

// File: rtl/cache_par_mask.sv
module cache_par_mask
    import cache_par_pkg::*;
#(
    parameter int NSETS = 8,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(NSETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  period,
    input  logic [IDX_W-1:0]  rd_index,
    input  logic              clr_en,
    input  wayvec_t           clr_vec,
    input  logic [IDX_W-1:0]  fl_index,
    output wayvec_t           rd_mask,
    output wayvec_t           fl_mask
);

    wayvec_t          mask_q [NSETS];
    logic [CNT_W-1:0] cnt_q;
    logic             scrub_fire;

    assign scrub_fire = (period != '0) && (cnt_q >= period);

    always_ff @(posedge clk) begin
        if (rst || period == '0 || scrub_fire) cnt_q <= '0;
        else                                   cnt_q <= cnt_q + 1'b1;
    end

    // Restore first, then apply this cycle's error clears (error wins).
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) mask_q[s] <= '1;
        end else begin
            for (int s = 0; s < NSETS; s++) begin
                wayvec_t nxt;
                nxt = scrub_fire ? '1 : mask_q[s];
                if (clr_en && rd_index == IDX_W'(s)) nxt = nxt & ~clr_vec;
                mask_q[s] <= nxt;
            end
        end
    end

    assign rd_mask = mask_q[rd_index];
    assign fl_mask = mask_q[fl_index];

endmodule

// File: rtl/cache_par_lru.sv
module cache_par_lru
    import cache_par_pkg::*;
#(
    parameter int NSETS = 8,
    localparam int IDX_W = $clog2(NSETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_v,
    input  logic [IDX_W-1:0]  hit_idx,
    input  wayidx_t           hit_way,
    input  logic              fill_v,
    input  logic [IDX_W-1:0]  fill_idx,
    input  wayidx_t           fill_way,
    output agevec_t           fill_age
);

    agevec_t age_q [NSETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                for (int w = 0; w < NWAYS; w++) age_q[s][w] <= age_t'(w);
            end
        end else begin
            for (int s = 0; s < NSETS; s++) begin
                if (fill_v && fill_idx == IDX_W'(s))
                    age_q[s] <= touch_age(age_q[s], fill_way);
                else if (hit_v && hit_idx == IDX_W'(s))
                    age_q[s] <= touch_age(age_q[s], hit_way);
            end
        end
    end

    assign fill_age = age_q[fill_idx];

endmodule

// File: rtl/cache_parity_lru.sv
module cache_parity_lru
    import cache_par_pkg::*;
#(
    parameter int NSETS  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CNT_W-1:0]           scrub_period,
    input  logic                       req_valid,
    input  logic [$clog2(NSETS)-1:0]   req_index,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic [DATA_W-1:0]          rsp_data,
    output logic                       rsp_perr,
    output logic                       rsp_uncache,
    input  logic                       fill_valid,
    input  logic [$clog2(NSETS)-1:0]   fill_index,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic [DATA_W-1:0]          fill_data,
    input  logic                       fill_bad_par
);

    localparam int IDX_W = $clog2(NSETS);

    logic [NWAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [NWAYS-1:0][DATA_W-1:0] rd_data;
    wayvec_t rd_vld, rd_bad, fl_vld, rd_mask, fill_mask;
    wayvec_t err_vec, match_vec;
    agevec_t fill_age;
    pick_t   victim;
    look_t   look;
    logic    fill_we;

    cache_par_store #(.NSETS(NSETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .rd_index(req_index), .rd_tag(rd_tag), .rd_data(rd_data),
        .rd_vld(rd_vld), .rd_bad(rd_bad),
        .fl_index(fill_index), .fl_vld(fl_vld),
        .wr_en(fill_we), .wr_way(victim.way),
        .wr_tag(fill_tag), .wr_data(fill_data), .wr_flip(fill_bad_par)
    );

    cache_par_mask #(.NSETS(NSETS), .CNT_W(CNT_W)) u_mask (
        .clk(clk), .rst(rst), .period(scrub_period),
        .rd_index(req_index), .clr_en(req_valid), .clr_vec(err_vec),
        .fl_index(fill_index), .rd_mask(rd_mask), .fl_mask(fill_mask)
    );

    cache_par_lru #(.NSETS(NSETS)) u_lru (
        .clk(clk), .rst(rst),
        .hit_v(req_valid && look.hit), .hit_idx(req_index), .hit_way(look.way),
        .fill_v(fill_we), .fill_idx(fill_index), .fill_way(victim.way),
        .fill_age(fill_age)
    );

    // Lookup evaluation over enabled ways only.
    always_comb begin
        err_vec = rd_bad & rd_mask;
        for (int w = 0; w < NWAYS; w++) begin
            match_vec[w] = rd_mask[w] && rd_vld[w] && !rd_bad[w] &&
                           (rd_tag[w] == req_tag);
        end
        look.hit     = |match_vec;
        look.perr    = |err_vec;
        look.uncache = (rd_mask == '0);
        look.way     = lowest_way(match_vec);
    end

    assign victim  = choose_victim(fill_mask, fl_vld, fill_age);
    assign fill_we = fill_valid && victim.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_data    <= '0;
            rsp_perr    <= 1'b0;
            rsp_uncache <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit     <= look.hit;
                rsp_data    <= look.hit ? rd_data[look.way] : '0;
                rsp_perr    <= look.perr;
                rsp_uncache <= look.uncache;
            end
        end
    end

endmodule

// File: rtl/cache_parity_lru_chk.sv
module cache_parity_lru_chk
    import cache_par_pkg::*;
#(
    parameter int NSETS = 8,
    localparam int IDX_W = $clog2(NSETS)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_index,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_uncache,
    input logic             fill_valid,
    input logic             fill_we,
    input wayvec_t          fill_mask,
    input wayidx_t          victim_way,
    input wayvec_t          err_vec,
    input logic             scrub_fire,
    input wayvec_t          mask_all [NSETS]
);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1
    AST_UNCACHE_MISS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_uncache) |-> !rsp_hit); // R8
    AST_NO_FILL_UNCACHE: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_mask == '0) |-> !fill_we); // R8
    AST_VICTIM_ENABLED: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> fill_mask[victim_way]); // R6
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && err_vec != '0) |=>
        ((mask_all[$past(req_index)] & $past(err_vec)) == '0)); // R4 R10

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        AST_SCRUB_RESTORES: assert property (@(posedge clk) disable iff (rst)
            (scrub_fire && !(req_valid && req_index == IDX_W'(s))) |=>
            (mask_all[s] == '1)); // R9
        AST_MASK_RISE_ON_SCRUB: assert property (@(posedge clk) disable iff (rst)
            ((mask_all[s] & ~$past(mask_all[s])) != '0) |-> $past(scrub_fire)); // R9
    end

endmodule

bind cache_parity_lru cache_parity_lru_chk #(.NSETS(NSETS)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_index(req_index),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_uncache(rsp_uncache),
    .fill_valid(fill_valid), .fill_we(fill_we), .fill_mask(fill_mask),
    .victim_way(victim.way), .err_vec(err_vec),
    .scrub_fire(u_mask.scrub_fire), .mask_all(u_mask.mask_q)
);

// File: tb/tb_cache_parity_lru.sv
module tb_cache_parity_lru;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] scrub_period = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_index = '0;
    logic [7:0]  req_tag = '0;
    logic        rsp_valid, rsp_hit, rsp_perr, rsp_uncache;
    logic [15:0] rsp_data;
    logic        fill_valid = 1'b0;
    logic [2:0]  fill_index = '0;
    logic [7:0]  fill_tag = '0;
    logic [15:0] fill_data = '0;
    logic        fill_bad_par = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic r_vld, r_hit, r_perr, r_unc;
    logic [15:0] r_data;

    always #4 clk = ~clk;

    cache_parity_lru dut (
        .clk(clk), .rst(rst), .scrub_period(scrub_period),
        .req_valid(req_valid), .req_index(req_index), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .rsp_perr(rsp_perr), .rsp_uncache(rsp_uncache),
        .fill_valid(fill_valid), .fill_index(fill_index), .fill_tag(fill_tag),
        .fill_data(fill_data), .fill_bad_par(fill_bad_par)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic drive_req(input logic [2:0] idx, input logic [7:0] tag);
        req_valid = 1'b1; req_index = idx; req_tag = tag;
    endtask

    task automatic drive_fill(input logic [2:0] idx, input logic [7:0] tag,
                              input logic [15:0] data, input logic bad);
        fill_valid = 1'b1; fill_index = idx; fill_tag = tag;
        fill_data = data; fill_bad_par = bad;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0; fill_bad_par = 1'b0;
        r_vld = rsp_valid; r_hit = rsp_hit; r_data = rsp_data;
        r_perr = rsp_perr; r_unc = rsp_uncache;
    endtask

    task automatic lookup(input logic [2:0] idx, input logic [7:0] tag);
        drive_req(idx, tag);
        finish_cycle();
    endtask

    task automatic fill(input logic [2:0] idx, input logic [7:0] tag,
                        input logic [15:0] data, input logic bad);
        drive_fill(idx, tag, data, bad);
        finish_cycle();
    endtask

    task automatic expect_line(input string what, input logic [2:0] idx,
                               input logic [7:0] tag, input logic hit,
                               input logic [15:0] data);
        lookup(idx, tag);
        chk({what, " hit"}, 32'(r_hit), 32'(hit));
        if (hit) chk({what, " data"}, 32'(r_data), 32'(data));
    endtask

    task automatic t_reset();
        chk("R12 rsp_valid after reset", 32'(rsp_valid), 0);
        lookup(3'd0, 8'h00);
        chk("R1 rsp_valid one cycle after request", 32'(r_vld), 1);
        chk("R12 empty cache misses", 32'(r_hit), 0);
        chk("R12 no parity error on empty set", 32'(r_perr), 0);
        chk("R12 masks start enabled", 32'(r_unc), 0);
        @(negedge clk);
        chk("R1 rsp_valid drops without request", 32'(rsp_valid), 0);
    endtask

    task automatic t_basic();
        fill(3'd1, 8'h10, 16'h1234, 1'b0);
        fill(3'd1, 8'h11, 16'hBEEF, 1'b0);
        expect_line("R2 R3 first line", 3'd1, 8'h10, 1'b1, 16'h1234);
        chk("R3 good parity no error", 32'(r_perr), 0);
        expect_line("R2 second line", 3'd1, 8'h11, 1'b1, 16'hBEEF);
        expect_line("R2 absent tag", 3'd1, 8'h12, 1'b0, 16'h0);
        expect_line("R2 same tag other set", 3'd2, 8'h10, 1'b0, 16'h0);
    endtask

    task automatic t_lru();
        fill(3'd2, 8'hA0, 16'h00A0, 1'b0);
        fill(3'd2, 8'hA1, 16'h00A1, 1'b0);
        fill(3'd2, 8'hA2, 16'h00A2, 1'b0);
        fill(3'd2, 8'hA3, 16'h00A3, 1'b0);
        lookup(3'd2, 8'hA0);
        chk("R7 hit before refresh", 32'(r_hit), 1);
        fill(3'd2, 8'hA4, 16'h00A4, 1'b0);
        expect_line("R7 touched line kept", 3'd2, 8'hA0, 1'b1, 16'h00A0);
        expect_line("R6 LRU line evicted", 3'd2, 8'hA1, 1'b0, 16'h0);
        expect_line("R6 other line kept", 3'd2, 8'hA2, 1'b1, 16'h00A2);
        expect_line("R6 newest line present", 3'd2, 8'hA4, 1'b1, 16'h00A4);
    endtask

    task automatic t_parity();
        fill(3'd3, 8'h30, 16'h3030, 1'b1);
        fill(3'd3, 8'h31, 16'h3131, 1'b0);
        lookup(3'd3, 8'h30);
        chk("R3 R4 bad parity reported", 32'(r_perr), 1);
        chk("R4 bad line not a hit", 32'(r_hit), 0);
        lookup(3'd3, 8'h30);
        chk("R5 disabled way not checked", 32'(r_perr), 0);
        chk("R5 disabled way not matched", 32'(r_hit), 0);
        expect_line("R4 good neighbour hit", 3'd3, 8'h31, 1'b1, 16'h3131);
        fill(3'd3, 8'h32, 16'h3232, 1'b0);
        fill(3'd3, 8'h33, 16'h3333, 1'b0);
        fill(3'd3, 8'h34, 16'h3434, 1'b0);
        expect_line("R6 disabled oldest way skipped", 3'd3, 8'h31, 1'b0, 16'h0);
        expect_line("R6 fill landed", 3'd3, 8'h34, 1'b1, 16'h3434);
    endtask

    task automatic t_uncache();
        for (int i = 1; i <= 4; i++) fill(3'd4, 8'(i), 16'(i * 3), 1'b1);
        lookup(3'd4, 8'h01);
        chk("R4 all four errors", 32'(r_perr), 1);
        lookup(3'd4, 8'h01);
        chk("R8 set uncacheable", 32'(r_unc), 1);
        chk("R8 uncacheable misses", 32'(r_hit), 0);
        fill(3'd4, 8'h09, 16'h0909, 1'b0);
        lookup(3'd4, 8'h09);
        chk("R8 fill dropped", 32'(r_hit), 0);
        chk("R8 still uncacheable", 32'(r_unc), 1);
    endtask

    task automatic t_scrub();
        scrub_period = 16'd40;
        repeat (20) @(negedge clk);
        lookup(3'd4, 8'h09);
        chk("R9 no restore before period", 32'(r_unc), 1);
        repeat (30) @(negedge clk);
        lookup(3'd4, 8'h09);
        chk("R9 masks restored", 32'(r_unc), 0);
        chk("R9 restored ways checked again", 32'(r_perr), 1);
        scrub_period = 16'd0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_collide();
        fill(3'd5, 8'h50, 16'h5050, 1'b1);
        scrub_period = 16'd12;
        repeat (12) @(negedge clk);
        lookup(3'd5, 8'h50);
        scrub_period = 16'd0;
        chk("R10 error seen on restore edge", 32'(r_perr), 1);
        fill(3'd5, 8'h51, 16'h5151, 1'b0);
        fill(3'd5, 8'h52, 16'h5252, 1'b0);
        fill(3'd5, 8'h53, 16'h5353, 1'b0);
        fill(3'd5, 8'h54, 16'h5454, 1'b0);
        expect_line("R10 error beat restore", 3'd5, 8'h51, 1'b0, 16'h0);
        expect_line("R10 newest present", 3'd5, 8'h54, 1'b1, 16'h5454);
    endtask

    task automatic t_same_cycle();
        fill(3'd7, 8'h70, 16'h7070, 1'b0);
        fill(3'd7, 8'h71, 16'h7171, 1'b0);
        fill(3'd7, 8'h72, 16'h7272, 1'b0);
        drive_req(3'd7, 8'h73);
        drive_fill(3'd7, 8'h73, 16'h7373, 1'b0);
        finish_cycle();
        chk("R11 lookup sees pre-fill contents", 32'(r_hit), 0);
        expect_line("R11 concurrent fill stored", 3'd7, 8'h73, 1'b1, 16'h7373);
        drive_req(3'd7, 8'h70);
        drive_fill(3'd7, 8'h74, 16'h7474, 1'b0);
        finish_cycle();
        chk("R11 concurrent lookup hits old line", 32'(r_hit), 1);
        chk("R11 concurrent lookup data", 32'(r_data), 32'h7070);
        expect_line("R11 victim from old ages", 3'd7, 8'h70, 1'b0, 16'h0);
        expect_line("R11 filled line present", 3'd7, 8'h74, 1'b1, 16'h7474);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lru();
        t_parity();
        t_uncache();
        t_scrub();
        t_collide();
        t_same_cycle();
        summary();
    end

endmodule